// File: doc/BRIEF.md
# Call and Return Stack Sequencer

This block owns the stack pointer of a small accumulator machine and performs every stack access against a 256-byte internal RAM. One strobe per operation starts it. The operations are a one-byte push and pop, a subroutine link that saves a 16-bit return address, an interrupt entry that saves the interrupted address and marks a priority level as in service, a plain return, and an interrupt return that also releases the most urgent level in service. The block does not decode opcodes and does not arbitrate interrupts. The caller supplies the call address, says whether the call was a long (3-byte) or short (2-byte) form, and supplies the level being entered.

Each RAM access takes one clock, so the stack pointer never needs a second port. While a frame is in flight, `busy_o` is high. One clock after the final access, `done_o` pulses for one cycle. From that cycle on, the popped byte or rebuilt address is held on the outputs.

Top module: `stack_seq`

## Requirements
- R1: A push raises the pointer by one and writes `din_i` at the raised location. A push with pointer 0x07 writes address 0x08 and leaves the pointer at 0x08.
- R2: A pop reads the byte at the current pointer, presents it on `dout_o`, and then lowers the pointer by one.
- R3: A call stores the link address in two writes: the low byte at pointer+1, then the high byte at pointer+2. The pointer finishes 2 higher. The link address is `call_addr_i`+3 when `call_long_i`=1 and `call_addr_i`+2 when `call_long_i`=0. It is also shown on `ret_addr_o`.
- R4: An interrupt entry stores `call_addr_i` unchanged, low byte first and then high byte. When it completes, it sets bit `irq_lvl_i` of `irq_act_o`.
- R5: A return reads the high byte at the pointer, then the low byte at pointer−1. It outputs {high,low} on `ret_addr_o` and leaves the pointer 2 lower.
- R6: An interrupt return does everything a return does and also clears the highest-numbered set bit of `irq_act_o`. With no bit set, it behaves exactly like a return and `irq_act_o` stays 0.
- R7: After reset: pointer 0x07, `busy_o`=0, `done_o`=0, `dout_o`=0x00, `ret_addr_o`=0x0000, `irq_act_o`=0.
- R8: Push and pop keep `busy_o` high for one cycle. Call, interrupt entry, return and interrupt return keep it high for two cycles. `done_o` is high for exactly the one cycle after the last access.
- R9: A strobe raised while `busy_o` is high has no effect: no RAM write, and no pointer or output change.
- R10: When several strobes are raised together, only one is served. The order of precedence is: interrupt return, return, interrupt entry, call, pop, push.
- R11: The pointer wraps modulo 256. A push at 0xFF writes address 0x00, and a pop at 0x00 leaves 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Pop strobe |
| call_i | input | 1 | Subroutine call strobe |
| irq_i | input | 1 | Interrupt entry strobe |
| ret_i | input | 1 | Return strobe |
| reti_i | input | 1 | Interrupt return strobe |
| din_i | input | DW (8) | Byte to push |
| call_addr_i | input | 2*DW (16) | Address of the call, or the interrupted address |
| call_long_i | input | 1 | 1: 3-byte call form, 0: 2-byte form |
| irq_lvl_i | input | LW (1) | Priority level being entered |
| dout_o | output | DW (8) | Last popped byte |
| ret_addr_o | output | 2*DW (16) | Last stored or recovered link address |
| ram_en_o | output | 1 | RAM access this cycle |
| ram_we_o | output | 1 | RAM write this cycle |
| ram_addr_o | output | AW (8) | RAM address |
| ram_wdata_o | output | DW (8) | RAM write data |
| ram_rdata_i | input | DW (8) | RAM read data, same cycle as address |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sp_o | output | AW (8) | Current stack pointer |
| irq_act_o | output | NLVL (2) | Levels in service, one bit per level |

## Verification
Two events can meet in one cycle here: a new strobe can arrive while a two-byte frame is still in its access cycles, and several strobes can be raised together. The bench raises a push during the second cycle of a call. It judges the result by the untouched RAM word above the frame and by the pointer after completion. It then raises mixed strobe sets (push with pop with return, interrupt entry with call, interrupt return with return). It checks which frame was served from the pointer, the link address (+0 for an interrupt entry versus +3 for a call) and the level bits.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

  typedef enum logic [2:0] {
    OP_NONE, OP_PUSH, OP_POP, OP_CALL, OP_IRQ, OP_RET, OP_RETI
  } op_e;

  typedef enum logic [1:0] {S_IDLE, S_ONE, S_TWO} st_e;

  // strobe vector order: {reti, ret, irq, call, pop, push}
  function automatic op_e pick_op(input logic [5:0] stb);
    if (stb[5]) return OP_RETI;
    if (stb[4]) return OP_RET;
    if (stb[3]) return OP_IRQ;
    if (stb[2]) return OP_CALL;
    if (stb[1]) return OP_POP;
    if (stb[0]) return OP_PUSH;
    return OP_NONE;
  endfunction

  function automatic logic op_is_wide(input op_e op);
    return (op == OP_CALL) || (op == OP_IRQ) || (op == OP_RET) || (op == OP_RETI);
  endfunction

  function automatic logic op_is_write(input op_e op);
    return (op == OP_PUSH) || (op == OP_CALL) || (op == OP_IRQ);
  endfunction

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int AW = 8,
  parameter logic [AW-1:0] RST_VAL = 'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          step_up,
  output logic [AW-1:0] sp_o
);
  logic [AW-1:0] sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       sp_q <= RST_VAL;
    else if (step_en) sp_q <= step_up ? sp_q + AW'(1) : sp_q - AW'(1);
  end

  assign sp_o = sp_q;
endmodule

// File: rtl/stk_lvl.sv
module stk_lvl #(
  parameter int NLVL = 2,
  localparam int LW = (NLVL > 1) ? $clog2(NLVL) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [LW-1:0]   set_lvl,
  input  logic            clr_en,
  output logic [NLVL-1:0] act_o
);
  logic [NLVL-1:0] clr_mask;

  // one-hot mask of the most urgent level in service
  always_comb begin
    clr_mask = '0;
    for (int i = 0; i < NLVL; i++) begin
      if (act_o[i]) begin
        clr_mask    = '0;
        clr_mask[i] = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                              bit_q <= 1'b0;
      else if (set_en && set_lvl == LW'(g))    bit_q <= 1'b1;
      else if (clr_en && clr_mask[g])          bit_q <= 1'b0;
    end
    assign act_o[g] = bit_q;
  end

  AST_RETI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en && (act_o != '0)) |=>
      ($countones(act_o) + 1 == $past($countones(act_o)))); // R6

  AST_RETI_EMPTY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en && (act_o == '0)) |=> (act_o == '0)); // R6
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stack_seq_pkg::*;
#(
  parameter int AW   = 8,
  parameter int DW   = 8,
  parameter int NLVL = 2,
  localparam int PC_W = 2 * DW,
  localparam int LW   = (NLVL > 1) ? $clog2(NLVL) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [5:0]      stb_i,
  input  logic [DW-1:0]   din_i,
  input  logic [PC_W-1:0] call_addr_i,
  input  logic            call_long_i,
  input  logic [LW-1:0]   irq_lvl_i,
  input  logic [AW-1:0]   sp_i,
  input  logic [DW-1:0]   ram_rdata_i,
  output logic            ram_en_o,
  output logic            ram_we_o,
  output logic [AW-1:0]   ram_addr_o,
  output logic [DW-1:0]   ram_wdata_o,
  output logic            step_en_o,
  output logic            step_up_o,
  output logic            lvl_set_o,
  output logic [LW-1:0]   lvl_idx_o,
  output logic            lvl_clr_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [DW-1:0]   dout_o,
  output logic [PC_W-1:0] ret_addr_o
);
  // link address to save: interrupted address as is, else past the call
  function automatic logic [PC_W-1:0] link_addr(input logic [PC_W-1:0] a,
                                                input logic is_irq, input logic lng);
    if (is_irq) return a;
    return a + (lng ? PC_W'(3) : PC_W'(2));
  endfunction

  st_e             st_q;
  op_e             op_q, req_op;
  logic [DW-1:0]   din_q, dout_q;
  logic [PC_W-1:0] link_q;
  logic [LW-1:0]   lvl_q;
  logic            done_q, accept, acc, wr, last_acc;

  assign req_op   = pick_op(stb_i);
  assign accept   = (st_q == S_IDLE) && (req_op != OP_NONE);
  assign acc      = (st_q != S_IDLE);
  assign wr       = acc && op_is_write(op_q);
  assign last_acc = ((st_q == S_ONE) && !op_is_wide(op_q)) || (st_q == S_TWO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      op_q   <= OP_NONE;
      din_q  <= '0;
      dout_q <= '0;
      link_q <= '0;
      lvl_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_acc;
      unique case (st_q)
        S_IDLE: if (accept) begin
          st_q  <= S_ONE;
          op_q  <= req_op;
          din_q <= din_i;
          lvl_q <= irq_lvl_i;
          if (op_is_wide(req_op) && op_is_write(req_op))
            link_q <= link_addr(call_addr_i, req_op == OP_IRQ, call_long_i);
        end
        S_ONE: begin
          st_q <= op_is_wide(op_q) ? S_TWO : S_IDLE;
          if (op_q == OP_POP)                             dout_q <= ram_rdata_i;
          else if (op_q == OP_RET || op_q == OP_RETI)     link_q[DW +: DW] <= ram_rdata_i;
        end
        S_TWO: begin
          st_q <= S_IDLE;
          if (op_q == OP_RET || op_q == OP_RETI)          link_q[0 +: DW] <= ram_rdata_i;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign ram_en_o    = acc;
  assign ram_we_o    = wr;
  assign ram_addr_o  = wr ? sp_i + AW'(1) : sp_i;
  assign ram_wdata_o = (op_q == OP_PUSH) ? din_q
                     : (st_q == S_ONE)   ? link_q[0 +: DW] : link_q[DW +: DW];
  assign step_en_o   = acc;
  assign step_up_o   = op_is_write(op_q);
  assign lvl_set_o   = (st_q == S_TWO) && (op_q == OP_IRQ);
  assign lvl_clr_o   = (st_q == S_TWO) && (op_q == OP_RETI);
  assign lvl_idx_o   = lvl_q;
  assign busy_o      = acc;
  assign done_o      = done_q;
  assign dout_o      = dout_q;
  assign ret_addr_o  = link_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R8

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && $past(acc) && $past(st_q) == S_ONE) |=> !acc); // R8
endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter int AW   = 8,
  parameter int DW   = 8,
  parameter int NLVL = 2,
  parameter logic [AW-1:0] SP_RST = 'h07,
  localparam int PC_W = 2 * DW,
  localparam int LW   = (NLVL > 1) ? $clog2(NLVL) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic            call_i,
  input  logic            irq_i,
  input  logic            ret_i,
  input  logic            reti_i,
  input  logic [DW-1:0]   din_i,
  input  logic [PC_W-1:0] call_addr_i,
  input  logic            call_long_i,
  input  logic [LW-1:0]   irq_lvl_i,
  output logic [DW-1:0]   dout_o,
  output logic [PC_W-1:0] ret_addr_o,
  output logic            ram_en_o,
  output logic            ram_we_o,
  output logic [AW-1:0]   ram_addr_o,
  output logic [DW-1:0]   ram_wdata_o,
  input  logic [DW-1:0]   ram_rdata_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [AW-1:0]   sp_o,
  output logic [NLVL-1:0] irq_act_o
);
  logic          step_en, step_up, lvl_set, lvl_clr;
  logic [LW-1:0] lvl_idx;
  logic [5:0]    stb;

  assign stb = {reti_i, ret_i, irq_i, call_i, pop_i, push_i};

  stk_ptr #(.AW(AW), .RST_VAL(SP_RST)) u_ptr (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .step_up(step_up), .sp_o(sp_o));

  stk_ctrl #(.AW(AW), .DW(DW), .NLVL(NLVL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .stb_i(stb), .din_i(din_i),
    .call_addr_i(call_addr_i), .call_long_i(call_long_i), .irq_lvl_i(irq_lvl_i),
    .sp_i(sp_o), .ram_rdata_i(ram_rdata_i),
    .ram_en_o(ram_en_o), .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o),
    .ram_wdata_o(ram_wdata_o), .step_en_o(step_en), .step_up_o(step_up),
    .lvl_set_o(lvl_set), .lvl_idx_o(lvl_idx), .lvl_clr_o(lvl_clr),
    .busy_o(busy_o), .done_o(done_o), .dout_o(dout_o), .ret_addr_o(ret_addr_o));

  stk_lvl #(.NLVL(NLVL)) u_lvl (
    .clk(clk), .rst_n(rst_n), .set_en(lvl_set), .set_lvl(lvl_idx),
    .clr_en(lvl_clr), .act_o(irq_act_o));

  AST_PUSH_PREINC: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en_o && ram_we_o) |=> (sp_o == $past(ram_addr_o))); // R1

  AST_POP_POSTDEC: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en_o && !ram_we_o) |=> (sp_o == $past(ram_addr_o) - AW'(1))); // R2

  AST_DONE_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o))); // R8

  AST_SP_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> $stable(sp_o)); // R9
endmodule

// File: tb/stack_seq_tb.sv
`timescale 1ns/1ps
module stack_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 0, pop_i = 0, call_i = 0, irq_i = 0, ret_i = 0, reti_i = 0;
  logic [7:0]  din_i = '0;
  logic [15:0] call_addr_i = '0;
  logic        call_long_i = 1'b0;
  logic [0:0]  irq_lvl_i = '0;
  logic [7:0]  dout_o, ram_addr_o, ram_wdata_o, ram_rdata_i, sp_o;
  logic [15:0] ret_addr_o;
  logic        ram_en_o, ram_we_o, busy_o, done_o;
  logic [1:0]  irq_act_o;
  logic [7:0]  mem [256];
  int          n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  stack_seq dut_i (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .call_i(call_i),
    .irq_i(irq_i), .ret_i(ret_i), .reti_i(reti_i), .din_i(din_i),
    .call_addr_i(call_addr_i), .call_long_i(call_long_i), .irq_lvl_i(irq_lvl_i),
    .dout_o(dout_o), .ret_addr_o(ret_addr_o), .ram_en_o(ram_en_o), .ram_we_o(ram_we_o),
    .ram_addr_o(ram_addr_o), .ram_wdata_o(ram_wdata_o), .ram_rdata_i(ram_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .sp_o(sp_o), .irq_act_o(irq_act_o));

  assign ram_rdata_i = mem[ram_addr_o];
  always @(posedge clk) if (ram_en_o && ram_we_o) mem[ram_addr_o] <= ram_wdata_o;

  // strobe mask: bit0 push, bit1 pop, bit2 call, bit3 irq, bit4 ret, bit5 reti
  typedef struct packed {
    logic [5:0]  stb;
    logic [7:0]  din;
    logic [15:0] addr;
    logic        lng;
    logic        lvl;
    logic [7:0]  esp;
    logic [7:0]  edout;
    logic [15:0] eret;
    logic [1:0]  eact;
    logic [2:0]  elat;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{6'h01, 8'hA5, 16'h0000, 1'b0, 1'b0, 8'h08, 8'h00, 16'h0000, 2'b00, 3'd1},
    '{6'h01, 8'h3C, 16'h0000, 1'b0, 1'b0, 8'h09, 8'h00, 16'h0000, 2'b00, 3'd1},
    '{6'h02, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h08, 8'h3C, 16'h0000, 2'b00, 3'd1},
    '{6'h04, 8'h00, 16'h1234, 1'b1, 1'b0, 8'h0A, 8'h3C, 16'h1237, 2'b00, 3'd2},
    '{6'h04, 8'h00, 16'h20FE, 1'b0, 1'b0, 8'h0C, 8'h3C, 16'h2100, 2'b00, 3'd2},
    '{6'h10, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h0A, 8'h3C, 16'h2100, 2'b00, 3'd2},
    '{6'h08, 8'h00, 16'h0456, 1'b0, 1'b0, 8'h0C, 8'h3C, 16'h0456, 2'b01, 3'd2},
    '{6'h08, 8'h00, 16'h0789, 1'b0, 1'b1, 8'h0E, 8'h3C, 16'h0789, 2'b11, 3'd2},
    '{6'h20, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h0C, 8'h3C, 16'h0789, 2'b01, 3'd2},
    '{6'h20, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h0A, 8'h3C, 16'h0456, 2'b00, 3'd2},
    '{6'h20, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h08, 8'h3C, 16'h1237, 2'b00, 3'd2},
    '{6'h02, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h07, 8'hA5, 16'h1237, 2'b00, 3'd1}
  };

  function automatic string req_of(input logic [5:0] stb);
    if (stb[5]) return "R6";
    if (stb[4]) return "R5";
    if (stb[3]) return "R4";
    if (stb[2]) return "R3";
    if (stb[1]) return "R2";
    return "R1";
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic set_stb(input logic [5:0] s);
    {reti_i, ret_i, irq_i, call_i, pop_i, push_i} = s;
  endtask

  task automatic run_op(input logic [5:0] s, input logic [7:0] d, input logic [15:0] a,
                        input logic lng, input logic lvl, output int lat);
    @(negedge clk);
    set_stb(s); din_i = d; call_addr_i = a; call_long_i = lng; irq_lvl_i = lvl;
    @(negedge clk);
    set_stb('0);
    lat = 0;
    while (!done_o && lat < 8) begin @(negedge clk); lat++; end
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected completion");
    report();
  end

  initial begin
    int lat;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    chk("R7", "sp", sp_o, 8'h07);
    chk("R7", "busy", busy_o, 0);
    chk("R7", "done", done_o, 0);
    chk("R7", "dout", dout_o, 0);
    chk("R7", "ret", ret_addr_o, 0);
    chk("R7", "act", irq_act_o, 0);

    for (int v = 0; v < 12; v++) begin
      run_op(VEC[v].stb, VEC[v].din, VEC[v].addr, VEC[v].lng, VEC[v].lvl, lat);
      chk(req_of(VEC[v].stb), "sp", sp_o, VEC[v].esp);
      chk(req_of(VEC[v].stb), "dout", dout_o, VEC[v].edout);
      chk(req_of(VEC[v].stb), "ret_addr", ret_addr_o, VEC[v].eret);
      chk(req_of(VEC[v].stb), "irq_act", irq_act_o, VEC[v].eact);
      chk("R8", "latency", lat, VEC[v].elat);
      @(negedge clk);
      chk("R8", "done pulse width", done_o, 0);
    end

    // R3 low byte then high byte of 0x1237 at 0x09/0x0A
    chk("R3", "mem[09]", mem[8'h09], 8'h37);
    chk("R3", "mem[0A]", mem[8'h0A], 8'h12);
    // R4 interrupted address 0x0789 stored low first at 0x0D/0x0E
    chk("R4", "mem[0D]", mem[8'h0D], 8'h89);
    chk("R4", "mem[0E]", mem[8'h0E], 8'h07);

    // R9: push strobe during second cycle of a call is dropped
    @(negedge clk);
    set_stb(6'h04); call_addr_i = 16'h0100; call_long_i = 1'b1; din_i = 8'hFF;
    @(negedge clk);
    set_stb(6'h01);
    @(negedge clk);
    set_stb('0);
    lat = 0;
    while (!done_o && lat < 8) begin @(negedge clk); lat++; end
    repeat (3) @(negedge clk);
    chk("R9", "sp", sp_o, 8'h09);
    chk("R9", "mem[0A] untouched", mem[8'h0A], 8'h12);
    chk("R3", "mem[08] low", mem[8'h08], 8'h03);
    chk("R3", "mem[09] high", mem[8'h09], 8'h01);
    chk("R9", "busy idle", busy_o, 0);

    // R10: push+pop+ret -> ret wins
    run_op(6'h13, 8'h5A, 16'h0000, 1'b0, 1'b0, lat);
    chk("R10", "ret_addr", ret_addr_o, 16'h0103);
    chk("R10", "sp", sp_o, 8'h07);
    // R10: push+pop -> pop wins
    run_op(6'h03, 8'h5A, 16'h0000, 1'b0, 1'b0, lat);
    chk("R10", "sp", sp_o, 8'h06);
    chk("R10", "dout", dout_o, 8'h00);
    // R10: irq+call -> irq wins, address not advanced
    run_op(6'h0C, 8'h00, 16'h0300, 1'b1, 1'b1, lat);
    chk("R10", "ret_addr", ret_addr_o, 16'h0300);
    chk("R10", "irq_act", irq_act_o, 2'b10);
    chk("R10", "sp", sp_o, 8'h08);
    // R10: reti+ret -> reti wins, level released
    run_op(6'h30, 8'h00, 16'h0000, 1'b0, 1'b0, lat);
    chk("R10", "irq_act", irq_act_o, 2'b00);
    chk("R10", "sp", sp_o, 8'h06);

    // R11: wrap below zero and back
    for (int k = 0; k < 7; k++) run_op(6'h02, 8'h00, 16'h0000, 1'b0, 1'b0, lat);
    chk("R11", "sp after pops", sp_o, 8'hFF);
    run_op(6'h01, 8'hE1, 16'h0000, 1'b0, 1'b0, lat);
    chk("R11", "sp after push", sp_o, 8'h00);
    chk("R11", "mem[00]", mem[8'h00], 8'hE1);
    run_op(6'h02, 8'h00, 16'h0000, 1'b0, 1'b0, lat);
    chk("R11", "dout", dout_o, 8'hE1);
    chk("R11", "sp after pop", sp_o, 8'hFF);

    report();
  end
endmodule